// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block reads a matrix keypad of `ROWS` row lines and `COLS` column lines (4 x 4 by default) and turns one key press into an 8-bit ASCII hexadecimal character. The rows are outputs driven by the block and are active low. The columns are inputs that rest high through external pull-ups. A pressed key links its row to its column, so that column reads low while that row is driven low.

Each key is handled in three phases. First, with every row driven low, the block waits until all columns read high, so the previous key is known to be up. It then polls for any low column and confirms the press by sampling again after a debounce interval of `DEBOUNCE_CYC` clock cycles. Finally it drives one row low at a time, from row 0 upward, to locate the key. The result appears as a one-cycle `key_valid` strobe with `key_code`.

The column inputs pass through a synchronizer of `SYNC_STAGES` flops. After every change of the row drive, the block waits `SETTLE_CYC` cycles before it uses the columns.

Top module: `kpad_scan_top`

## Requirements
- R1: While reset is held and in the cycle after it, `row_drv` is 4'b0000, `key_valid` is 0 and `key_code` is 8'h00.
- R2: After a key has been reported, no further key is reported until all column inputs have read high with all rows driven low, even if a different key is pressed before the first one is let go.
- R3: With all columns high, no report is made and `row_drv` stays 4'b0000 (bit r of `row_drv` drives row r, and bit c of `col_in` is column c).
- R4: A press is reported only if a column is still low `DEBOUNCE_CYC` cycles after the first low sample. A press shorter than that produces no report, and no report comes earlier than `DEBOUNCE_CYC` cycles after the press.
- R5: During the row walk, `row_drv` drives exactly one row low, in the order 4'b1110, 4'b1101, 4'b1011, 4'b0111. The walk stops at the first row in which a column reads low.
- R6: When several keys are low together, the lowest row that shows a low column wins, and within that row the lowest-numbered low column wins.
- R7: The reported code is the ASCII hex digit of row*4+col: 8'h30..8'h39 for values 0..9 and 8'h41..8'h46 for values 10..15.
- R8: `key_valid` is high for exactly one cycle per report, and `key_code` keeps its last value while `key_valid` is low.
- R9: If no row shows a low column during the walk, the press is dropped with no report, and `row_drv` returns to 4'b0000.
- R10: A key held for a long time is reported exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_in | input | COLS | Column lines, pulled high; low means a closed key on a driven row |
| row_drv | output | ROWS | Row drive, active low |
| key_valid | output | 1 | One-cycle strobe marking a new key code |
| key_code | output | 8 | ASCII hex character of the last key found |

## Verification
The hardest case to reach from the ports is a false press. That happens when a press survives the debounce resample but is gone by the time the row walk samples the columns, so the walk ends at the last row with nothing found. The stimulus reaches this window by watching `row_drv`: it holds a key on row 3, waits until the walk drives row 0 low, and then releases the key before the walk reaches row 3. It then checks that no code appears and that the rows return to all low. A second hard case is the release wait with two overlapping keys: a second key is pressed while the first is still down, so the columns never return high in between.

// File: rtl/kpad_pkg.sv
// Shared types and helpers for the keypad scanner.
// Assumes at most 16 keys, so every key number fits in one hex digit.
package kpad_pkg;

    typedef enum logic [1:0] {
        KS_RELEASE  = 2'd0,
        KS_POLL     = 2'd1,
        KS_DEBOUNCE = 2'd2,
        KS_SCAN     = 2'd3
    } kpad_state_e;

    // Map a key number 0..15 to its ASCII hex character
    function automatic logic [7:0] kpad_hex_ascii(input logic [7:0] v);
        if (v < 8'd10) return 8'h30 + v;
        else           return 8'h37 + v;
    endfunction

endpackage

// File: rtl/kpad_col_sync.sv
// Multi-flop synchronizer for the asynchronous column lines.
// Assumes STAGES >= 2; resets to all ones (the idle, released level).
module kpad_col_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw columns through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/kpad_timer.sv
// Loadable down-counter shared by the settle and debounce waits.
// done is high while the count is zero; a load takes priority over counting.
module kpad_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Count down to zero and hold there
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/kpad_col_pick.sv
// Picks the lowest-numbered low column and forms the ASCII code for the key
// at (row_idx, column). Assumes ROWS*COLS <= 16 and that at least one column
// is low when the code is used.
module kpad_col_pick
    import kpad_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic [$clog2(ROWS)-1:0] row_idx,
    input  logic [COLS-1:0]         cols_n,
    output logic [7:0]              code
);
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

    logic [CW-1:0] col_sel;
    logic [7:0]    key_num;

    // Priority pick: scanning downward leaves the lowest low column selected
    always_comb begin
        col_sel = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (!cols_n[c]) col_sel = CW'(c);
        end
    end

    // Key number and its character
    always_comb begin
        key_num = 8'(row_idx) * 8'(COLS) + 8'(col_sel);
        code    = kpad_hex_ascii(key_num);
    end
endmodule

// File: rtl/kpad_ctrl.sv
// Scan sequencer: release wait, poll, debounce resample, then row walk.
// Assumes cols_s is already synchronized and SETTLE_CYC covers the
// synchronizer delay. The report is registered at the row-walk hit.
module kpad_ctrl
    import kpad_pkg::*;
#(
    parameter int ROWS         = 4,
    parameter int COLS         = 4,
    parameter int DEBOUNCE_CYC = 2_500_000,
    parameter int SETTLE_CYC   = 4,
    parameter int TW           = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COLS-1:0]         cols_s,
    input  logic                    timer_done,
    input  logic [7:0]              code_in,
    output logic                    timer_load,
    output logic [TW-1:0]           timer_val,
    output logic [ROWS-1:0]         row_drv,
    output logic [$clog2(ROWS)-1:0] row_idx,
    output logic                    key_valid,
    output logic [7:0]              key_code
);
    localparam int RW = $clog2(ROWS);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    kpad_state_e   state, state_nxt;
    logic [RW-1:0] idx_nxt;
    logic          all_high;
    logic          report;

    assign all_high = &cols_s;

    // Next-state, row step and timer load decisions
    always_comb begin
        state_nxt  = state;
        idx_nxt    = row_idx;
        timer_load = 1'b0;
        timer_val  = '0;
        report     = 1'b0;
        unique case (state)
            KS_RELEASE: begin
                if (timer_done && all_high) state_nxt = KS_POLL;
            end
            KS_POLL: begin
                if (!all_high) begin
                    state_nxt  = KS_DEBOUNCE;
                    timer_load = 1'b1;
                    timer_val  = TW'(DEBOUNCE_CYC);
                end
            end
            KS_DEBOUNCE: begin
                if (timer_done) begin
                    if (!all_high) begin
                        state_nxt  = KS_SCAN;
                        idx_nxt    = '0;
                        timer_load = 1'b1;
                        timer_val  = TW'(SETTLE_CYC);
                    end else begin
                        state_nxt = KS_POLL;
                    end
                end
            end
            KS_SCAN: begin
                if (timer_done) begin
                    if (!all_high) begin
                        report     = 1'b1;
                        state_nxt  = KS_RELEASE;
                        timer_load = 1'b1;
                        timer_val  = TW'(SETTLE_CYC);
                    end else if (row_idx == LAST_ROW) begin
                        state_nxt = KS_POLL;
                    end else begin
                        idx_nxt    = row_idx + 1'b1;
                        timer_load = 1'b1;
                        timer_val  = TW'(SETTLE_CYC);
                    end
                end
            end
            default: state_nxt = KS_RELEASE;
        endcase
    end

    // State and row index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= KS_RELEASE;
            row_idx <= '0;
        end else begin
            state   <= state_nxt;
            row_idx <= idx_nxt;
        end
    end

    // Registered report strobe and held code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_valid <= 1'b0;
            key_code  <= 8'h00;
        end else begin
            key_valid <= report;
            if (report) key_code <= code_in;
        end
    end

    // One row low during the walk, all rows low otherwise
    assign row_drv = (state == KS_SCAN) ? ~(ROWS'(1) << row_idx) : '0;
endmodule

// File: rtl/kpad_scan_top.sv
// Matrix keypad scanner top: synchronizer, shared timer, column picker and
// sequencer. Assumes pulled-up columns, active-low rows and ROWS*COLS <= 16.
module kpad_scan_top #(
    parameter int ROWS         = 4,
    parameter int COLS         = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int DEBOUNCE_CYC = 2_500_000,
    parameter int SETTLE_CYC   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_in,
    output logic [ROWS-1:0] row_drv,
    output logic            key_valid,
    output logic [7:0]      key_code
);
    localparam int TMAX = (DEBOUNCE_CYC > SETTLE_CYC) ? DEBOUNCE_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(ROWS);

    logic [COLS-1:0] cols_s;
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_done;
    logic [RW-1:0]   row_idx;
    logic [7:0]      code_w;

    kpad_col_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(col_in), .dout(cols_s)
    );

    kpad_timer #(.CW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    kpad_col_pick #(.ROWS(ROWS), .COLS(COLS)) u_pick (
        .row_idx(row_idx), .cols_n(cols_s), .code(code_w)
    );

    kpad_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .DEBOUNCE_CYC(DEBOUNCE_CYC),
        .SETTLE_CYC(SETTLE_CYC), .TW(TW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cols_s(cols_s), .timer_done(t_done),
        .code_in(code_w), .timer_load(t_load), .timer_val(t_val),
        .row_drv(row_drv), .row_idx(row_idx), .key_valid(key_valid),
        .key_code(key_code)
    );
endmodule

// File: rtl/kpad_scan_chk.sv
// Property checker for the keypad scanner, attached to the top by bind.
module kpad_scan_chk #(
    parameter int ROWS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_drv,
    input logic            key_valid,
    input logic [7:0]      key_code
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid); // R8

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> $stable(key_code)); // R8

    AST_ROW_DRIVE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (row_drv == '0) || ($countones(row_drv) == ROWS - 1)); // R5

    AST_CODE_IS_HEX: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ((key_code >= 8'h30 && key_code <= 8'h39) ||
                       (key_code >= 8'h41 && key_code <= 8'h46))); // R7

    AST_REPORT_FROM_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ($countones($past(row_drv)) == ROWS - 1)); // R5
endmodule

bind kpad_scan_top kpad_scan_chk #(.ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_drv(row_drv),
    .key_valid(key_valid), .key_code(key_code)
);

// File: tb/kpad_scan_top_tb_top.sv
// Scoreboard bench: stimulus tasks queue expected codes, a monitor compares.
module kpad_scan_top_tb_top;
    localparam int DEB = 50;
    localparam int SET = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] col_in;
    logic [3:0] row_drv;
    logic       key_valid;
    logic [7:0] key_code;
    logic [15:0] press_map = '0;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  n_valid = 0;
    bit  prev_v = 1'b0;
    bit  finished = 1'b0;
    byte exp_q[$];
    string hex_chars = "0123456789ABCDEF";

    always #4 clk = ~clk;

    kpad_scan_top #(
        .ROWS(4), .COLS(4), .SYNC_STAGES(2), .DEBOUNCE_CYC(DEB), .SETTLE_CYC(SET)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .col_in(col_in), .row_drv(row_drv),
        .key_valid(key_valid), .key_code(key_code)
    );

    // Keypad model: a closed key pulls its column low when its row is driven low
    always_comb begin
        col_in = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (press_map[r*4+c] && !row_drv[r]) col_in[c] = 1'b0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic byte exp_code(input int r, input int c);
        return byte'(hex_chars[r*4+c]);
    endfunction

    // Monitor: pop and compare every reported code, check the strobe width
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v) check("R8 strobe lasts one cycle", key_valid, 0);
            if (key_valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    check("R4/R2 unexpected report", 1, 0);
                end else begin
                    byte e;
                    e = exp_q.pop_front();
                    check("R7 key code", key_code, e);
                end
            end
            prev_v = key_valid;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Press one key for hold cycles, expect its code, release, rest
    task automatic tap(input int r, input int c, input int hold);
        exp_q.push_back(exp_code(r, c));
        press_map[r*4+c] = 1'b1;
        idle(hold);
        press_map = '0;
        idle(40);
    endtask

    task automatic wait_rows(input logic [3:0] pat, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (row_drv === pat) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int v0;
        int lat;
        bit ok;
        repeat (5) @(negedge clk);
        check("R1 reset row drive", row_drv, 4'b0000);
        check("R1 reset strobe", key_valid, 0);
        check("R1 reset code", key_code, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle code", key_code, 8'h00);
        idle(50);
        check("R3 idle no report", n_valid, 0);
        check("R3 idle rows all low", row_drv, 4'b0000);

        // R4: latency is at least the debounce interval
        exp_q.push_back(exp_code(0, 0));
        press_map[0] = 1'b1;
        lat = 0;
        while (!key_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        check("R4 report not before debounce", (lat >= DEB) ? 1 : 0, 1);
        press_map = '0;
        idle(40);

        // R7: every key in turn
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                tap(r, c, 150);
        check("R7 all codes consumed", exp_q.size(), 0);

        // R4: glitch shorter than debounce
        v0 = n_valid;
        press_map[6] = 1'b1;
        idle(20);
        press_map = '0;
        idle(200);
        check("R4 short press ignored", n_valid, v0);

        // R4: bouncing contact then a steady hold gives one report
        v0 = n_valid;
        exp_q.push_back(exp_code(2, 1));
        for (int k = 0; k < 5; k++) begin
            press_map[9] = 1'b1; idle(3);
            press_map[9] = 1'b0; idle(3);
        end
        press_map[9] = 1'b1;
        idle(200);
        press_map = '0;
        idle(40);
        check("R4 bouncy press reported once", n_valid, v0 + 1);

        // R10: long hold reports once
        v0 = n_valid;
        exp_q.push_back(exp_code(2, 2));
        press_map[10] = 1'b1;
        idle(800);
        press_map = '0;
        idle(40);
        check("R10 long hold single report", n_valid, v0 + 1);

        // R2: overlapping second key is not taken before all keys are up
        v0 = n_valid;
        exp_q.push_back(exp_code(0, 1));
        press_map[1] = 1'b1;
        idle(150);
        press_map[15] = 1'b1;
        idle(20);
        press_map[1] = 1'b0;
        idle(300);
        check("R2 overlapped key not reported", n_valid, v0 + 1);
        press_map = '0;
        idle(60);
        check("R2 still one report after release", n_valid, v0 + 1);
        tap(1, 0, 150);
        check("R2 next key reported after release", n_valid, v0 + 2);

        // R6: column and row priority
        exp_q.push_back(exp_code(1, 1));
        press_map[5] = 1'b1; press_map[7] = 1'b1;
        idle(150); press_map = '0; idle(40);
        exp_q.push_back(exp_code(0, 3));
        press_map[3] = 1'b1; press_map[9] = 1'b1;
        idle(150); press_map = '0; idle(40);
        exp_q.push_back(exp_code(2, 2));
        press_map[12] = 1'b1; press_map[10] = 1'b1;
        idle(150); press_map = '0; idle(40);
        check("R6 priority codes consumed", exp_q.size(), 0);

        // R5: row walk order for a key on row 3
        exp_q.push_back(exp_code(3, 2));
        press_map[14] = 1'b1;
        wait_rows(4'b1110, ok); check("R5 walk drives row 0", ok, 1);
        wait_rows(4'b1101, ok); check("R5 walk drives row 1", ok, 1);
        wait_rows(4'b1011, ok); check("R5 walk drives row 2", ok, 1);
        wait_rows(4'b0111, ok); check("R5 walk drives row 3", ok, 1);
        idle(60);
        press_map = '0;
        idle(40);
        check("R5 walk result consumed", exp_q.size(), 0);

        // R9: key lost during the walk
        v0 = n_valid;
        press_map[13] = 1'b1;
        wait_rows(4'b1110, ok);
        check("R9 walk started", ok, 1);
        press_map = '0;
        idle(100);
        check("R9 false press no report", n_valid, v0);
        check("R9 rows back to all low", row_drv, 4'b0000);
        check("R8 code held since last report", key_code, 8'h45);
        tap(1, 2, 150);
        check("R9 recovers after false press", n_valid, v0 + 1);

        idle(20);
        check("R7 queue empty at end", exp_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end
endmodule